// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

This block qualifies the digital output of an overvoltage comparator in a switching power converter. The comparator watches a scaled copy of the auxiliary-winding voltage against a 3 V reference, but that voltage only tracks the converter output while the power switch is off. The filter therefore takes a single sample of the comparator flag per switching cycle. The sample is placed a fixed number of clocks after the off-time window opens, so that ringing after turn-off can settle before the flag is read.

A trip seen at the strobe advances a consecutive-trip counter. Any cycle that closes without a trip returns the counter to zero. That includes a cycle where the strobe read a clean flag and a cycle whose off-time was too short for a strobe. When the counter reaches the trip limit (four by default), the block raises a latched fault that the supervisor uses to shut the converter down and start the auto-restart sequence. The fault stays set until the supervisor clears it. The counter value is brought out for debug.

Top module: `ovp_fault_filter`

## Requirements
- R1: After reset, `trip_cnt_o` is 0, `fault_o` is 0 and `fault_set_o` is 0.
- R2: The comparator flag is sampled only on the clock edge at which `off_win_i` is high and has already been high on the SETTLE_CLKS preceding edges (default 3, so on the fourth consecutive high edge). At every other edge, `cmp_trip_i` has no effect on `trip_cnt_o`.
- R3: At most one sample is taken per oscillator cycle, which runs from one `cyc_start_i` pulse to the next. An off-time window that reopens within the same cycle takes no second sample.
- R4: A sample with `cmp_trip_i` high adds one to `trip_cnt_o`. The count saturates at TRIP_LIMIT (default 4).
- R5: A sample with `cmp_trip_i` low sets `trip_cnt_o` to 0 on that edge.
- R6: When `cyc_start_i` is high and the cycle that is ending took no sample with a trip, `trip_cnt_o` goes to 0 on that edge. This covers a cycle with no sample at all.
- R7: On the edge where `trip_cnt_o` first reaches TRIP_LIMIT while `fault_o` is low, `fault_o` rises and `fault_set_o` is high for exactly that one clock.
- R8: `fault_o` stays high until `fault_clr_i` is sampled high. That edge sets both `fault_o` and `trip_cnt_o` to 0, and the clear wins over a set or a count on the same edge.
- R9: A sample taken on the same edge as `cyc_start_i` belongs to the new cycle. It counts from the value left after the ending cycle has been judged, and it uses up the new cycle's single sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | One-clock pulse at the start of each oscillator cycle |
| off_win_i | input | 1 | High while the power switch is off |
| cmp_trip_i | input | 1 | Comparator flag: auxiliary sense above the reference |
| fault_clr_i | input | 1 | Supervisor clear of the latched fault |
| fault_o | output | 1 | Latched overvoltage fault |
| fault_set_o | output | 1 | One-clock pulse when the fault is raised |
| trip_cnt_o | output | CNT_W (3) | Consecutive-trip counter, for debug |

## Verification
A wrong internal state shows at the ports as a counter step at the wrong edge. If the settle count or the one-sample flag is off, the counter moves one or more clocks away from the expected strobe edge, or it moves a second time within a cycle, and this appears on `trip_cnt_o` in the same clock. If the per-cycle trip memory is wrong, the counter is not reset, or is reset when it should not be, at the next `cyc_start_i`. That error then moves `fault_o` by whole switching cycles. A behavioural model in the bench is compared with all three outputs at every clock, so any of these errors is seen on the first edge where it diverges.

// File: rtl/ovp_filter_pkg.sv
package ovp_filter_pkg;

  // Saturating increment used by the trip counter.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Width able to hold 0..max.
  function automatic int unsigned span_bits(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/ovp_strobe_gen.sv
module ovp_strobe_gen #(
  parameter int unsigned SETTLE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic off_win,
  output logic strobe
);
  import ovp_filter_pkg::*;

  localparam int unsigned RUN_W = span_bits(SETTLE_CLKS);

  logic settled;
  logic taken_q, taken_d;
  logic taken_eff;

  generate
    if (SETTLE_CLKS == 0) begin : g_no_settle
      assign settled = off_win;
    end else begin : g_settle
      logic [RUN_W-1:0] run_q, run_d;
      logic             run_en;

      // Count edges seen inside the window, holding at the settle length.
      always_comb begin
        run_en = 1'b0;
        run_d  = run_q;
        if (!off_win) begin
          run_en = (run_q != '0);
          run_d  = '0;
        end else if (run_q != RUN_W'(SETTLE_CLKS)) begin
          run_en = 1'b1;
          run_d  = run_q + RUN_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= '0;
        end else if (run_en) begin
          run_q <= run_d;
        end
      end

      assign settled = off_win && (run_q == RUN_W'(SETTLE_CLKS));
    end
  endgenerate

  // A cycle start frees the sample slot for the cycle it opens.
  assign taken_eff = cyc_start ? 1'b0 : taken_q;
  assign strobe    = settled && !taken_eff;

  always_comb begin
    taken_d = taken_eff | strobe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
    end else begin
      taken_q <= taken_d;
    end
  end

endmodule

// File: rtl/ovp_trip_counter.sv
module ovp_trip_counter #(
  parameter int unsigned TRIP_LIMIT = 4,
  parameter int unsigned CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             strobe,
  input  logic             trip,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d
);
  import ovp_filter_pkg::*;

  localparam logic [CNT_W-1:0] LIM = CNT_W'(TRIP_LIMIT);

  logic             hit_q, hit_d;
  logic [CNT_W-1:0] base;
  logic             hit_now;
  logic             cnt_en;

  assign hit_now = strobe && trip;

  always_comb begin
    // Judge the ending cycle first, then apply a sample of the new one.
    base = (cyc_start && !hit_q) ? '0 : cnt_q;
    if (strobe) begin
      cnt_d = trip ? CNT_W'(sat_step(int'(base), TRIP_LIMIT)) : '0;
    end else begin
      cnt_d = base;
    end
    if (clr) begin
      cnt_d = '0;
    end
    cnt_en = (cnt_d != cnt_q);

    hit_d = cyc_start ? hit_now : (hit_q | hit_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  logic unused_lim;
  assign unused_lim = ^LIM;

endmodule

// File: rtl/ovp_fault_latch.sv
module ovp_fault_latch #(
  parameter int unsigned TRIP_LIMIT = 4,
  parameter int unsigned CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             clr,
  output logic             fault_q,
  output logic             set_q
);
  logic fault_d, set_d;
  logic arm;

  assign arm = (cnt_nxt == CNT_W'(TRIP_LIMIT));

  always_comb begin
    set_d   = arm && !fault_q && !clr;
    fault_d = clr ? 1'b0 : (fault_q | set_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      set_q   <= set_d;
    end
  end

endmodule

// File: rtl/ovp_fault_filter.sv
module ovp_fault_filter #(
  parameter int unsigned SETTLE_CLKS = 3,
  parameter int unsigned TRIP_LIMIT  = 4,
  parameter int unsigned CNT_W       = ovp_filter_pkg::span_bits(TRIP_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start_i,
  input  logic             off_win_i,
  input  logic             cmp_trip_i,
  input  logic             fault_clr_i,
  output logic             fault_o,
  output logic             fault_set_o,
  output logic [CNT_W-1:0] trip_cnt_o
);
  logic             strobe_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cnt_nxt_w;

  ovp_strobe_gen #(
    .SETTLE_CLKS(SETTLE_CLKS)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start_i),
    .off_win  (off_win_i),
    .strobe   (strobe_w)
  );

  ovp_trip_counter #(
    .TRIP_LIMIT(TRIP_LIMIT),
    .CNT_W     (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start_i),
    .strobe   (strobe_w),
    .trip     (cmp_trip_i),
    .clr      (fault_clr_i),
    .cnt_q    (cnt_w),
    .cnt_d    (cnt_nxt_w)
  );

  ovp_fault_latch #(
    .TRIP_LIMIT(TRIP_LIMIT),
    .CNT_W     (CNT_W)
  ) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_nxt(cnt_nxt_w),
    .clr    (fault_clr_i),
    .fault_q(fault_o),
    .set_q  (fault_set_o)
  );

  assign trip_cnt_o = cnt_w;

endmodule

// File: rtl/ovp_fault_filter_chk.sv
module ovp_fault_filter_chk #(
  parameter int unsigned TRIP_LIMIT = 4,
  parameter int unsigned CNT_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_start_i,
  input logic             off_win_i,
  input logic             cmp_trip_i,
  input logic             fault_clr_i,
  input logic             fault_o,
  input logic             fault_set_o,
  input logic [CNT_W-1:0] trip_cnt_o,
  input logic             strobe_w
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= cyc_start_i ? strobe_w : (seen_q | strobe_w);
    end
  end

  p_strobe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_w |-> off_win_i);

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_w && !cyc_start_i && !fault_clr_i) |=> $stable(trip_cnt_o));

  p_one_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_w && !cyc_start_i) |-> !seen_q);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_cnt_o <= CNT_W'(TRIP_LIMIT));

  p_clean_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_w && !cmp_trip_i) |=> (trip_cnt_o == '0));

  p_set_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set_o |-> (fault_o && trip_cnt_o == CNT_W'(TRIP_LIMIT)));

  p_rise_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> fault_set_o);

  p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i) |=> fault_o);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr_i |=> (!fault_o && !fault_set_o && trip_cnt_o == '0));

endmodule

bind ovp_fault_filter ovp_fault_filter_chk #(
  .TRIP_LIMIT(TRIP_LIMIT),
  .CNT_W     (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_start_i(cyc_start_i),
  .off_win_i  (off_win_i),
  .cmp_trip_i (cmp_trip_i),
  .fault_clr_i(fault_clr_i),
  .fault_o    (fault_o),
  .fault_set_o(fault_set_o),
  .trip_cnt_o (trip_cnt_o),
  .strobe_w   (strobe_w)
);

// File: tb/ovp_fault_filter_tb.sv
`timescale 1ns/1ps
module ovp_fault_filter_tb_top;
  localparam int SETTLE = 3;
  localparam int LIMIT  = 4;
  localparam int CW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, off_win = 1'b0, trip = 1'b0, clr = 1'b0;
  logic fault, fault_set;
  logic [CW-1:0] cnt;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ovp_fault_filter #(.SETTLE_CLKS(SETTLE), .TRIP_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc_start), .off_win_i(off_win),
    .cmp_trip_i(trip), .fault_clr_i(clr), .fault_o(fault),
    .fault_set_o(fault_set), .trip_cnt_o(cnt)
  );

  // Behavioural reference: integers updated once per rising edge.
  int m_run = 0, m_cnt = 0;
  bit m_used = 0, m_trip_seen = 0, m_fault = 0, m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_used = 0; m_trip_seen = 0; m_fault = 0; m_pulse = 0;
    end else begin
      bit fire, used_now;
      int val;
      used_now = cyc_start ? 1'b0 : m_used;
      fire = off_win && (m_run >= SETTLE) && !used_now;
      val = m_cnt;
      if (cyc_start && !m_trip_seen) val = 0;
      if (fire) val = trip ? ((val + 1 > LIMIT) ? LIMIT : val + 1) : 0;
      if (clr) val = 0;
      m_pulse = !clr && !m_fault && (val == LIMIT);
      if (clr) m_fault = 0; else if (m_pulse) m_fault = 1;
      m_trip_seen = cyc_start ? (fire && trip) : (m_trip_seen || (fire && trip));
      m_used = used_now || fire;
      m_run = off_win ? m_run + 1 : 0;
      m_cnt = val;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "trip_cnt_o vs model", int'(cnt), m_cnt);
      check(cur_req, "fault_o vs model", int'(fault), int'(m_fault));
      check(cur_req, "fault_set_o vs model", int'(fault_set), int'(m_pulse));
    end
  end

  // One switching cycle: start pulse, low gap, window; trip level at the
  // strobe clock (window index SETTLE) and elsewhere given separately.
  task automatic sw_cycle(input int gap, input int win, input bit t_strobe, input bit t_other);
    @(negedge clk); cyc_start = 1; off_win = 0; trip = t_other;
    @(negedge clk); cyc_start = 0;
    for (int g = 0; g < gap; g++) @(negedge clk);
    for (int j = 0; j < win; j++) begin
      off_win = 1;
      trip = (j == SETTLE) ? t_strobe : t_other;
      @(negedge clk);
    end
    off_win = 0; trip = t_other;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset count", int'(cnt), 0);
    check("R1", "reset fault", int'(fault), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4/R7: four trip cycles raise the fault.
    cur_req = "R4";
    for (int k = 1; k <= 3; k++) begin
      sw_cycle(2, 6, 1, 0);
      check("R4", "count after trip cycle", int'(cnt), k);
    end
    cur_req = "R7";
    sw_cycle(2, 6, 1, 0);
    check("R7", "fault after four trips", int'(fault), 1);
    check("R4", "count at limit", int'(cnt), LIMIT);

    // R4/R8: saturate and hold.
    cur_req = "R8";
    sw_cycle(2, 6, 1, 0);
    check("R4", "saturated count", int'(cnt), LIMIT);
    sw_cycle(2, 6, 0, 0);
    check("R8", "fault held after clean cycle", int'(fault), 1);
    pulse_clear();
    @(negedge clk);
    check("R8", "fault cleared", int'(fault), 0);
    check("R8", "count cleared", int'(cnt), 0);

    // R5: clean sample resets a run.
    cur_req = "R5";
    for (int k = 0; k < 3; k++) sw_cycle(1, 5, 1, 0);
    check("R5", "count before clean sample", int'(cnt), 3);
    sw_cycle(1, 5, 0, 1);
    check("R5", "count after clean sample", int'(cnt), 0);

    // R6: a cycle with a window too short for a strobe.
    cur_req = "R6";
    sw_cycle(1, 5, 1, 0);
    sw_cycle(1, 5, 1, 0);
    sw_cycle(1, SETTLE, 1, 1);
    check("R6", "count held inside short cycle", int'(cnt), 2);
    sw_cycle(1, 5, 1, 0);
    check("R6", "count restarted after empty cycle", int'(cnt), 1);

    // R2: trips everywhere except at the strobe.
    cur_req = "R2";
    sw_cycle(3, 7, 0, 1);
    check("R2", "noise outside strobe ignored", int'(cnt), 0);
    sw_cycle(0, 4, 1, 0);
    check("R2", "strobe on fourth high edge", int'(cnt), 1);

    // R3: reopened window in the same cycle takes no second sample.
    cur_req = "R3";
    sw_cycle(1, 5, 1, 0);
    check("R3", "count before reopen", int'(cnt), 2);
    @(negedge clk); cyc_start = 1;
    @(negedge clk); cyc_start = 0;
    for (int j = 0; j < 5; j++) begin off_win = 1; trip = (j == SETTLE); @(negedge clk); end
    off_win = 0; @(negedge clk);
    for (int j = 0; j < 6; j++) begin off_win = 1; trip = 1; @(negedge clk); end
    off_win = 0; trip = 0; @(negedge clk);
    check("R3", "single sample per cycle", int'(cnt), 3);

    // R8: clear on the very edge the fault would set.
    cur_req = "R8";
    @(negedge clk); cyc_start = 1;
    @(negedge clk); cyc_start = 0;
    for (int j = 0; j < 5; j++) begin
      off_win = 1; trip = 1; clr = (j == SETTLE); @(negedge clk);
    end
    off_win = 0; trip = 0; clr = 0; @(negedge clk);
    check("R8", "clear beats set", int'(fault), 0);
    check("R8", "count zero after clear", int'(cnt), 0);

    // R9: strobe coinciding with the cycle start.
    cur_req = "R9";
    sw_cycle(1, 5, 1, 0);
    check("R9", "count before coincident strobe", int'(cnt), 1);
    @(negedge clk); cyc_start = 1;
    @(negedge clk); cyc_start = 0;
    for (int j = 0; j < SETTLE; j++) begin off_win = 1; trip = 0; @(negedge clk); end
    cyc_start = 1; trip = 1; @(negedge clk);
    cyc_start = 0; @(negedge clk); @(negedge clk);
    off_win = 0; trip = 0; @(negedge clk);
    check("R9", "empty cycle cleared then new sample counted", int'(cnt), 1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule